// File: doc/BRIEF.md
# Protection register commit controller

This block holds two 32-bit protection words for an on-chip flash array. One word grants read access per block and the other grants program access per block. Each word has a volatile working copy and a committed copy. Software writes the working copies over a small register bus, and the new values steer the protection outputs from the next cycle on. Software can therefore try a setting before making it permanent.

A commit is started by writing a target value into the target register and then writing the control register with its go bit set. The block stays busy for a fixed number of cycles, which stands in for programming the flash cells. At the end it folds the chosen working copy into the committed copy. Committed bits can only ever go from 1 to 0. The top two bits of the read word form a debug-disable field. Only the special target value 0x900 commits that field; clearing both bits turns the debug interface off for good.

Two resets are provided. Power-on reset returns every committed bit to the erased state (all ones), which models a blank part. System reset keeps the committed copies and reloads each working copy from its committed copy.

Top module: `prot_commit_ctrl`

## Requirements
- R1: A bus write (sel=1, wr=1) at offset 0 or offset 1 loads the read or program working word. From the next cycle, `rd_blk_en` or `pg_blk_en` equals bits 29:0 of that word, and reading the same offset returns the whole word.
- R2: A write to offset 3 with bit 0 set, while the block is idle, starts a commit. For exactly 16 cycles, reads of offset 3 return 3 (bit 0 = commit pending, bit 1 = busy). After that they return 0.
- R3: When a commit ends with bit 0 of the target register (offset 2) set, the committed program word (read at offset 5) becomes its old value ANDed with the program working word. The committed read word is left as it was.
- R4: When a commit ends with target bit 0 clear and a target other than 0x900, only bits 29:0 of the committed read word (offset 4) are ANDed with the read working word. Bits 31:30 and the committed program word keep their values.
- R5: When a commit ends with target 0x900, all 32 bits of the committed read word, debug field included, are ANDed with the read working word.
- R6: No committed bit ever goes from 0 to 1 except through power-on reset. A commit of a 1 over a committed 0 leaves a 0.
- R7: A system reset (`rst_n` low at a clock edge) reloads both working words from their committed copies, clears the target register and abandons any running commit.
- R8: While busy, bus writes to offsets 0, 1, 2 and 3 are ignored.
- R9: `debug_enable` is 1 only while committed read-word bits 31:30 are both 1.
- R10: For each block i, `exec_only[i]` is 1 when its read working bit is 0 and its program working bit is 1.
- R11: Power-on reset (`pwr_on_n` low at a clock edge) sets both committed and both working words to all ones, clears the target and ends any commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| pwr_on_n | input | 1 | Synchronous active-low power-on reset, erases committed copies |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word offset: 0 read working, 1 program working, 2 target, 3 control, 4 read committed, 5 program committed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, 0 when not selected |
| rd_blk_en | output | 30 | Per-block read enable (working copy) |
| pg_blk_en | output | 30 | Per-block program enable (working copy) |
| exec_only | output | 30 | Per-block execute-only indication |
| debug_enable | output | 1 | Debug interface allowed |

## Verification
The commit is exercised with four target patterns: bit 0 set, a plain even value, the special value 0x900, and a repeat commit that tries to raise bits that were already cleared. Between them, these runs tell apart the choice of word, the masking of the debug field and the one-way rule. The working words are loaded with patterns that mix cleared read bits with set and cleared program bits, which separates the execute-only case from plain protection. Writes made while busy, and system resets that follow commits, show which state survives and which does not.

// File: rtl/prot_commit_pkg.sv
// Shared constants and types for the protection commit controller.
// Assumes 32-bit protection words with a two-bit debug field at the top.
package prot_commit_pkg;
    localparam int WORD_W   = 32;
    localparam int NBLK     = 30;
    localparam int DBG_LO   = 30;
    localparam int NWORD    = 2;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_RD_WORK = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PG_WORK = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_TARGET  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RD_COMM = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_PG_COMM = 3'd5;

    localparam logic [WORD_W-1:0] DBG_TARGET  = 32'h0000_0900;
    localparam logic [WORD_W-1:0] ERASED      = '1;

    typedef struct packed {
        logic rd_we;
        logic pg_we;
        logic tgt_we;
        logic go;
    } wr_strobe_t;
endpackage

// File: rtl/prot_regif.sv
// Register bus decode and readback.
// Turns bus writes into strobes, all gated off while a commit runs,
// and muxes the addressed register onto bus_rdata. Assumes single-cycle
// writes and a combinational read path.
module prot_regif
    import prot_commit_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              go_bit,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_work,
    input  logic [WORD_W-1:0] pg_work,
    input  logic [WORD_W-1:0] target,
    input  logic [WORD_W-1:0] rd_comm,
    input  logic [WORD_W-1:0] pg_comm,
    output wr_strobe_t        strb,
    output logic [WORD_W-1:0] bus_rdata
);
    logic wr_ok;

    // Write qualification: a write counts only when selected and idle
    assign wr_ok = bus_sel && bus_wr && !busy;

    // Strobe decode per offset
    always_comb begin
        strb.rd_we  = wr_ok && (bus_addr == OFS_RD_WORK);
        strb.pg_we  = wr_ok && (bus_addr == OFS_PG_WORK);
        strb.tgt_we = wr_ok && (bus_addr == OFS_TARGET);
        strb.go     = wr_ok && (bus_addr == OFS_CTRL) && go_bit;
    end

    // Readback mux; control shows pending in bit 0 and busy in bit 1
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_RD_WORK: bus_rdata = rd_work;
                OFS_PG_WORK: bus_rdata = pg_work;
                OFS_TARGET:  bus_rdata = target;
                OFS_CTRL:    bus_rdata = {{(WORD_W-2){1'b0}}, busy, busy};
                OFS_RD_COMM: bus_rdata = rd_comm;
                OFS_PG_COMM: bus_rdata = pg_comm;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/prot_commit_seq.sv
// Commit sequencer.
// Holds the target register, runs the fixed-latency busy window and,
// in its last cycle, raises a fire pulse with per-word commit masks.
// Assumes the target is not written while busy (the register decode
// ensures this), so the masks may be taken from the live target.
module prot_commit_seq
    import prot_commit_pkg::*;
#(
    parameter int COMMIT_LAT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_n,
    input  logic              tgt_we,
    input  logic              go,
    input  logic [WORD_W-1:0] tgt_wdata,
    output logic [WORD_W-1:0] target,
    output logic              busy,
    output logic              fire,
    output logic [WORD_W-1:0] rd_mask,
    output logic [WORD_W-1:0] pg_mask
);
    localparam int CNT_W = $clog2(COMMIT_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_LAT - 1);

    logic [CNT_W-1:0] cnt;
    logic             dbg_sel;

    // Target register and busy counter; either reset abandons a commit
    always_ff @(posedge clk) begin
        if (!pwr_on_n || !rst_n) begin
            target <= '0;
            busy   <= 1'b0;
            cnt    <= '0;
        end else begin
            if (tgt_we)
                target <= tgt_wdata;
            if (busy) begin
                if (cnt == '0)
                    busy <= 1'b0;
                else
                    cnt <= cnt - 1'b1;
            end else if (go) begin
                busy <= 1'b1;
                cnt  <= CNT_LOAD;
            end
        end
    end

    // Last busy cycle applies the commit
    assign fire    = busy && (cnt == '0);
    assign dbg_sel = (target == DBG_TARGET);

    // Mask selection: odd target picks the program word, else the read word
    always_comb begin
        pg_mask = target[0] ? ERASED : '0;
        for (int i = 0; i < WORD_W; i++)
            rd_mask[i] = !target[0] && ((i < DBG_LO) || dbg_sel);
    end
endmodule

// File: rtl/prot_word_store.sv
// One protection word: a working copy and a committed copy.
// The working copy follows software writes and reloads from the committed
// copy on system reset. The committed copy only loses ones, and only in
// bit positions set in the commit mask. Power-on reset erases both.
module prot_word_store #(
    parameter int          W    = 32,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_on_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         commit_fire,
    input  logic [W-1:0] commit_mask,
    output logic [W-1:0] work,
    output logic [W-1:0] committed
);
    // Working and committed state update
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            work      <= INIT;
            committed <= INIT;
        end else if (!rst_n) begin
            work <= committed;
        end else begin
            if (wr_en)
                work <= wdata;
            if (commit_fire)
                committed <= committed & (work | ~commit_mask);
        end
    end
endmodule

// File: rtl/prot_commit_ctrl.sv
// Top of the protection commit controller.
// Ties the register decode, the commit sequencer and one store per
// protection word together, and derives the per-block outputs.
// Assumes a single synchronous clock domain and synchronous resets.
module prot_commit_ctrl
    import prot_commit_pkg::*;
#(
    parameter int COMMIT_LAT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NBLK-1:0]   rd_blk_en,
    output logic [NBLK-1:0]   pg_blk_en,
    output logic [NBLK-1:0]   exec_only,
    output logic              debug_enable
);
    wr_strobe_t                    strb;
    logic                          busy;
    logic                          fire;
    logic [WORD_W-1:0]             target;
    logic [WORD_W-1:0]             rd_mask;
    logic [WORD_W-1:0]             pg_mask;
    logic [NWORD-1:0]              word_we;
    logic [NWORD-1:0][WORD_W-1:0]  word_mask;
    logic [NWORD-1:0][WORD_W-1:0]  word_work;
    logic [NWORD-1:0][WORD_W-1:0]  word_comm;
    logic [WORD_W-1:0]             rd_work;
    logic [WORD_W-1:0]             pg_work;
    logic [WORD_W-1:0]             rd_comm;
    logic [WORD_W-1:0]             pg_comm;

    prot_regif u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .go_bit    (bus_wdata[0]),
        .busy      (busy),
        .rd_work   (rd_work),
        .pg_work   (pg_work),
        .target    (target),
        .rd_comm   (rd_comm),
        .pg_comm   (pg_comm),
        .strb      (strb),
        .bus_rdata (bus_rdata)
    );

    prot_commit_seq #(.COMMIT_LAT(COMMIT_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on_n  (pwr_on_n),
        .tgt_we    (strb.tgt_we),
        .go        (strb.go),
        .tgt_wdata (bus_wdata),
        .target    (target),
        .busy      (busy),
        .fire      (fire),
        .rd_mask   (rd_mask),
        .pg_mask   (pg_mask)
    );

    // Word index 0 is the read word, index 1 the program word
    assign word_we   = {strb.pg_we, strb.rd_we};
    assign word_mask = {pg_mask, rd_mask};

    for (genvar g = 0; g < NWORD; g++) begin : g_word
        prot_word_store #(.W(WORD_W), .INIT(ERASED)) u_store (
            .clk         (clk),
            .rst_n       (rst_n),
            .pwr_on_n    (pwr_on_n),
            .wr_en       (word_we[g]),
            .wdata       (bus_wdata),
            .commit_fire (fire),
            .commit_mask (word_mask[g]),
            .work        (word_work[g]),
            .committed   (word_comm[g])
        );
    end

    assign rd_work = word_work[0];
    assign pg_work = word_work[1];
    assign rd_comm = word_comm[0];
    assign pg_comm = word_comm[1];

    // Per-block outputs follow the working copies at once
    assign rd_blk_en    = rd_work[NBLK-1:0];
    assign pg_blk_en    = pg_work[NBLK-1:0];
    assign exec_only    = ~rd_work[NBLK-1:0] & pg_work[NBLK-1:0];
    assign debug_enable = &rd_comm[WORD_W-1:DBG_LO];
endmodule

// File: rtl/prot_commit_chk.sv
// Assertion checker for the protection commit controller, bound to the top.
// Tracks the length of each busy window with its own counter.
module prot_commit_chk #(
    parameter int COMMIT_LAT = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_on_n,
    input logic        busy,
    input logic [31:0] rd_work,
    input logic [31:0] pg_work,
    input logic [31:0] target,
    input logic [31:0] rd_comm,
    input logic [31:0] pg_comm,
    input logic        debug_enable
);
    logic [31:0] run_len;

    // Consecutive busy cycles seen so far
    always_ff @(posedge clk) begin
        if (!pwr_on_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= '0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!pwr_on_n || !rst_n)
        busy |-> (run_len < COMMIT_LAT));

    p_busy_full_r2: assert property (@(posedge clk) disable iff (!pwr_on_n || !rst_n)
        ($fell(busy) && $past(rst_n)) |-> (run_len == COMMIT_LAT));

    p_no_set_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (((~$past(rd_comm)) & rd_comm) == '0) && (((~$past(pg_comm)) & pg_comm) == '0));

    p_idle_stable_r4: assert property (@(posedge clk) disable iff (!pwr_on_n)
        !busy |=> ($stable(rd_comm) && $stable(pg_comm)));

    p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!pwr_on_n || !rst_n)
        busy |=> ($stable(rd_work) && $stable(pg_work) && $stable(target)));

    p_dbg_sticky_r9: assert property (@(posedge clk) disable iff (!pwr_on_n)
        !debug_enable |=> !debug_enable);
endmodule

bind prot_commit_ctrl prot_commit_chk #(.COMMIT_LAT(COMMIT_LAT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on_n     (pwr_on_n),
    .busy         (busy),
    .rd_work      (rd_work),
    .pg_work      (pg_work),
    .target       (target),
    .rd_comm      (rd_comm),
    .pg_comm      (pg_comm),
    .debug_enable (debug_enable)
);

// File: tb/prot_commit_ctrl_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module prot_commit_ctrl_bench;
    localparam int LAT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [29:0] rd_blk_en, pg_blk_en, exec_only;
    logic        debug_enable;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prot_commit_ctrl u_prot_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on_n(pwr_on_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_blk_en(rd_blk_en), .pg_blk_en(pg_blk_en),
        .exec_only(exec_only), .debug_enable(debug_enable)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    logic [31:0] m_rw, m_pw, m_rc, m_pc, m_tg;
    logic        m_busy = 1'b0;
    int          m_rem = 0;
    logic        m_valid = 1'b0;

    function automatic logic [31:0] m_rdata(input logic [2:0] a);
        if (!bus_sel) return 32'd0;
        case (a)
            3'd0: return m_rw;
            3'd1: return m_pw;
            3'd2: return m_tg;
            3'd3: return {30'd0, m_busy, m_busy};
            3'd4: return m_rc;
            3'd5: return m_pc;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R1";
            3'd2: return "R8";
            3'd3: return "R2";
            default: return "R6";
        endcase
    endfunction

    // Model step at each edge, then compare a quarter period later
    always @(posedge clk) begin
        if (!pwr_on_n) begin
            m_rw = '1; m_pw = '1; m_rc = '1; m_pc = '1; m_tg = '0;
            m_busy = 1'b0; m_rem = 0; m_valid = 1'b1;
        end else if (!rst_n) begin
            m_rw = m_rc; m_pw = m_pc; m_tg = '0; m_busy = 1'b0; m_rem = 0;
        end else if (m_busy) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
                if (m_tg[0])                 m_pc = m_pc & m_pw;
                else if (m_tg == 32'h900)    m_rc = m_rc & m_rw;
                else                         m_rc = m_rc & (m_rw | 32'hC000_0000);
                m_busy = 1'b0;
            end
        end else if (bus_sel && bus_wr) begin
            case (bus_addr)
                3'd0: m_rw = bus_wdata;
                3'd1: m_pw = bus_wdata;
                3'd2: m_tg = bus_wdata;
                3'd3: if (bus_wdata[0]) begin m_busy = 1'b1; m_rem = LAT; end
                default: ;
            endcase
        end
        #5;
        if (m_valid && pwr_on_n) begin
            check(bus_rdata, m_rdata(bus_addr), addr_tag(bus_addr));
            check({2'b0, rd_blk_en}, {2'b0, m_rw[29:0]}, "R1");
            check({2'b0, pg_blk_en}, {2'b0, m_pw[29:0]}, "R1");
            check({2'b0, exec_only}, {2'b0, ~m_rw[29:0] & m_pw[29:0]}, "R10");
            check({31'b0, debug_enable}, {31'b0, &m_rc[31:30]}, "R9");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        check(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk); pwr_on_n = 1'b1; rst_n = 1'b1; bus_sel = 1'b1;
        // R11: erased state after power-on
        rd_chk(3'd4, 32'hFFFF_FFFF, "R11");
        rd_chk(3'd5, 32'hFFFF_FFFF, "R11");
        check({31'b0, debug_enable}, 32'd1, "R11");

        // R1 and R10: working words act at once
        wr(3'd0, 32'hFFFF_FFF0);
        rd_chk(3'd0, 32'hFFFF_FFF0, "R1");
        check({2'b0, exec_only}, 32'h0000_000F, "R10");
        wr(3'd1, 32'hFFFF_FFFE);
        rd_chk(3'd1, 32'hFFFF_FFFE, "R10");
        check({2'b0, exec_only}, 32'h0000_000E, "R10");

        // R7: system reset drops uncommitted changes
        sys_reset();
        rd_chk(3'd0, 32'hFFFF_FFFF, "R7");
        rd_chk(3'd1, 32'hFFFF_FFFF, "R7");

        // R4 with R2 and R8: plain even target, writes during busy ignored
        wr(3'd0, 32'h3FFF_FF0F);
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0001);
        rd_chk(3'd3, 32'h0000_0003, "R2");
        wr(3'd0, 32'h0000_0000);
        wr(3'd2, 32'h0000_0001);
        rd_chk(3'd0, 32'h3FFF_FF0F, "R8");
        rd_chk(3'd2, 32'h0000_0000, "R8");
        idle(14);
        rd_chk(3'd3, 32'h0000_0000, "R2");
        rd_chk(3'd4, 32'hFFFF_FF0F, "R4");
        rd_chk(3'd5, 32'hFFFF_FFFF, "R4");
        check({31'b0, debug_enable}, 32'd1, "R4");

        // R3: odd target commits the program word
        wr(3'd1, 32'hFFFF_00FF);
        wr(3'd2, 32'h0000_0001);
        wr(3'd3, 32'h0000_0001);
        idle(20);
        rd_chk(3'd5, 32'hFFFF_00FF, "R3");
        rd_chk(3'd4, 32'hFFFF_FF0F, "R3");

        // R6: raising bits through a commit has no effect
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0001);
        idle(20);
        rd_chk(3'd4, 32'hFFFF_FF0F, "R6");

        // R5 and R9: special target commits the debug field
        wr(3'd0, 32'h3FFF_FF0F);
        wr(3'd2, 32'h0000_0900);
        wr(3'd3, 32'h0000_0001);
        idle(20);
        rd_chk(3'd4, 32'h3FFF_FF0F, "R5");
        check({31'b0, debug_enable}, 32'd0, "R9");

        // R6 and R7: no way back, reset reloads committed values
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0000_0001);
        idle(20);
        rd_chk(3'd4, 32'h3FFF_FF0F, "R6");
        sys_reset();
        rd_chk(3'd0, 32'h3FFF_FF0F, "R7");
        rd_chk(3'd1, 32'hFFFF_00FF, "R7");
        rd_chk(3'd2, 32'h0000_0000, "R7");
        check({31'b0, debug_enable}, 32'd0, "R9");

        idle(2);
        finish_run();
    end
endmodule